// File: doc/BRIEF.md
# PWM Event Action Generator

This block is a single pulse-width-modulation channel driven by counter events. A 16-bit counter runs either downward from a programmable top value to zero, or upward from zero to that top value and back down. The counter reaching zero, the counter reaching the top value, and the counter matching each of two compare thresholds are single-cycle events. Each event changes one registered output according to a 12-bit action word. The action word holds one 2-bit action per event type, and compare matches have separate actions for up-counting and down-counting.

When several events fall in the same cycle, a fixed priority picks the one that acts. The top value and the two thresholds are staged internally. The running counter only picks up new values at a zero crossing, so a software update in mid-period never shortens or distorts the period in progress. Every pin is a plain level-sensitive control or status signal. No data stream crosses the boundary, so there is no handshake and no back-pressure.

Top module: `pwm_event_gen`

## Requirements
- R1: Each 2-bit action field is encoded as 00 keep, 01 invert, 10 drive low, 11 drive high. In `act_word`, bits 1:0 act on zero and bits 3:2 act on top-value match. Bits 5:4 act on compare A while counting up and bits 7:6 on compare A while counting down. Bits 9:8 act on compare B while counting up and bits 11:10 on compare B while counting down.
- R2: With `updown_mode`=0 the counter goes load value, load-1, …, 0, then reloads, giving a period of load+1 cycles. Only the zero, top-value, compare-A-down and compare-B-down events occur.
- R3: With `updown_mode`=1 the counter goes 0, 1, …, load, load-1, …, 1, then repeats, giving a period of 2×load cycles. Compare matches on the rising half use the up-count actions and matches on the falling half use the down-count actions.
- R4: With `updown_mode`=0 the up-count compare actions (bits 9:8 and 5:4) never affect the output.
- R5: A zero or top-value event in the same cycle as a compare event takes effect, and the compare action is discarded.
- R6: When compare A and compare B match in the same cycle, and neither zero nor top value does, the compare B action is applied.
- R7: When the load value is 0, zero and top-value events coincide every cycle, and the zero action is applied.
- R8: During reset `pwm_out` is low and the counter is 0.
- R9: While `enable` is low no event is generated, `pwm_out` holds its value, and the counter is forced to 0. After enable is raised, the first enabled cycle is therefore a zero event.
- R10: New load and compare values are adopted only in a cycle where the counter is 0 (or while disabled), so a period in progress keeps its length.
- R11: `pwm_out` is registered. It changes at the first clock edge after the cycle that holds the event, and it never changes without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the counter and generate events |
| updown_mode | input | 1 | 0 = count down only, 1 = count up then down |
| load_val | input | 16 | Counter top value (staged until zero) |
| cmpa_val | input | 16 | Compare A threshold (staged until zero) |
| cmpb_val | input | 16 | Compare B threshold (staged until zero) |
| act_word | input | 12 | Six 2-bit event actions, layout in R1 |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A counter that steps wrongly or turns around at the wrong count changes the number of high cycles per period. That shows within one period, and the bench counts high cycles over a whole period for every configuration. A staging register that captures at the wrong time moves the next output edge by a whole period difference at the next zero crossing. A wrong priority choice or wrong field decode flips the output level on the clock edge that follows the coinciding events. Each of these therefore appears within at most one period, usually within one cycle.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_FLIP = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  localparam int ACT_W    = 12;
  localparam int FLD_ZERO = 0;
  localparam int FLD_TOP  = 2;
  localparam int FLD_A_UP = 4;
  localparam int FLD_A_DN = 6;
  localparam int FLD_B_UP = 8;
  localparam int FLD_B_DN = 10;

  typedef struct packed {
    logic zero;
    logic top;
    logic a_up;
    logic a_dn;
    logic b_up;
    logic b_dn;
  } evt_t;

  function automatic act_e pick_field(input logic [ACT_W-1:0] w, input int lsb);
    return act_e'(w[lsb +: 2]);
  endfunction

endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic [N-1:0][W-1:0] d,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[i] <= '0;
      else if (upd) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         updown,
  input  logic [W-1:0] top_in,
  input  logic [W-1:0] top_q,
  output logic [W-1:0] cnt_q,
  output logic         dir_up_q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (!enable) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (cnt_q == '0) begin
      dir_up_q <= 1'b1;
      if (updown) cnt_q <= (top_in == '0) ? '0 : ONE;
      else        cnt_q <= top_in;
    end else if (!updown) begin
      dir_up_q <= 1'b0;
      cnt_q    <= cnt_q - ONE;
    end else if (dir_up_q) begin
      if (cnt_q >= top_q) begin
        dir_up_q <= 1'b0;
        cnt_q    <= cnt_q - ONE;
      end else begin
        cnt_q    <= cnt_q + ONE;
      end
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/pwm_event_decode.sv
module pwm_event_decode
  import pwm_evt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         enable,
  input  logic         cnt_up,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top_q,
  input  logic [W-1:0] cmpa_q,
  input  logic [W-1:0] cmpb_q,
  output evt_t         evt
);
  logic hit_a, hit_b;

  always_comb begin
    hit_a     = enable && (cnt == cmpa_q);
    hit_b     = enable && (cnt == cmpb_q);
    evt.zero  = enable && (cnt == '0);
    evt.top   = enable && (cnt == top_q);
    evt.a_up  = hit_a &&  cnt_up;
    evt.a_dn  = hit_a && !cnt_up;
    evt.b_up  = hit_b &&  cnt_up;
    evt.b_dn  = hit_b && !cnt_up;
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  evt_t             evt,
  input  logic [ACT_W-1:0] act_word,
  output act_e             sel_act,
  output logic             pwm_q
);
  always_comb begin
    if (evt.zero)      sel_act = pick_field(act_word, FLD_ZERO);
    else if (evt.top)  sel_act = pick_field(act_word, FLD_TOP);
    else if (evt.b_up) sel_act = pick_field(act_word, FLD_B_UP);
    else if (evt.b_dn) sel_act = pick_field(act_word, FLD_B_DN);
    else if (evt.a_up) sel_act = pick_field(act_word, FLD_A_UP);
    else if (evt.a_dn) sel_act = pick_field(act_word, FLD_A_DN);
    else               sel_act = ACT_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else begin
      case (sel_act)
        ACT_FLIP: pwm_q <= ~pwm_q;
        ACT_CLR:  pwm_q <= 1'b0;
        ACT_SET:  pwm_q <= 1'b1;
        default:  pwm_q <= pwm_q;
      endcase
    end
  end
endmodule

// File: rtl/pwm_event_gen.sv
module pwm_event_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             updown_mode,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmpa_val,
  input  logic [CNT_W-1:0] cmpb_val,
  input  logic [ACT_W-1:0] act_word,
  output logic             pwm_out
);
  localparam int NSTAGE = 3;

  logic [NSTAGE-1:0][CNT_W-1:0] stage_d, stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_up_q;
  logic             cnt_up;
  logic             stage_upd;
  evt_t             evt_w;
  act_e             sel_act_w;

  assign stage_d   = {cmpb_val, cmpa_val, load_val};
  assign stage_upd = !enable || (cnt_q == '0);
  assign cnt_up    = updown_mode && dir_up_q;

  pwm_shadow #(.W(CNT_W), .N(NSTAGE)) u_shadow (
    .clk (clk), .rst_n (rst_n), .upd (stage_upd), .d (stage_d), .q (stage_q)
  );

  pwm_timebase #(.W(CNT_W)) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .updown   (updown_mode),
    .top_in   (load_val),
    .top_q    (stage_q[0]),
    .cnt_q    (cnt_q),
    .dir_up_q (dir_up_q)
  );

  pwm_event_decode #(.W(CNT_W)) u_decode (
    .enable (enable),
    .cnt_up (cnt_up),
    .cnt    (cnt_q),
    .top_q  (stage_q[0]),
    .cmpa_q (stage_q[1]),
    .cmpb_q (stage_q[2]),
    .evt    (evt_w)
  );

  pwm_action_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_w),
    .act_word (act_word),
    .sel_act  (sel_act_w),
    .pwm_q    (pwm_out)
  );
endmodule

// File: rtl/pwm_event_gen_chk.sv
module pwm_event_gen_chk
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             updown_mode,
  input logic [ACT_W-1:0] act_word,
  input logic             pwm_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_q,
  input logic             dir_up,
  input evt_t             evt,
  input act_e             sel_act
);
  logic any_evt;
  assign any_evt = evt.zero | evt.top | evt.a_up | evt.a_dn | evt.b_up | evt.b_dn;

  // R8: held low through reset
  always_ff @(posedge clk) begin
    if (!rst_n) a_r8_reset_low: assert (pwm_out == 1'b0 && cnt == '0);
  end

  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pwm_out));

  a_r9_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0);

  a_r11_change_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(pwm_out));

  a_r10_top_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt != '0) |=> $stable(top_q));

  a_r10_cnt_within_top: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> cnt <= top_q);

  a_r3_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && updown_mode && dir_up && cnt != '0 && cnt >= top_q) |=> !dir_up);

  a_r6_b_over_a: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt.a_up || evt.a_dn) && (evt.b_up || evt.b_dn) && !evt.zero && !evt.top)
      |-> sel_act == act_e'(evt.b_up ? act_word[9:8] : act_word[11:10]));

  a_r5_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
    evt.zero |-> sel_act == act_e'(act_word[1:0]));
endmodule

bind pwm_event_gen pwm_event_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .updown_mode (updown_mode),
  .act_word    (act_word),
  .pwm_out     (pwm_out),
  .cnt         (cnt_q),
  .top_q       (stage_q[0]),
  .dir_up      (dir_up_q),
  .evt         (evt_w),
  .sel_act     (sel_act_w)
);

// File: tb/test_pwm_event_gen.sv
`timescale 1ns/1ps
module test_pwm_event_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        updown_mode = 1'b0;
  logic [15:0] load_val = '0;
  logic [15:0] cmpa_val = '0;
  logic [15:0] cmpb_val = '0;
  logic [11:0] act_word = '0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_event_gen i_pwm_event_gen (
    .clk (clk), .rst_n (rst_n), .enable (enable), .updown_mode (updown_mode),
    .load_val (load_val), .cmpa_val (cmpa_val), .cmpb_val (cmpb_val),
    .act_word (act_word), .pwm_out (pwm_out)
  );

  typedef struct packed {
    logic        mode;
    logic [15:0] ld;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [11:0] act;
    logic [7:0]  win;
    logic [7:0]  highs;
    logic [7:0]  req;
  } vec_t;

  // window = cycles counted, highs = expected high cycles in that window
  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b0, 16'd9,  16'd4, 16'd7, 12'h0C2, 8'd10, 8'd4,  8'd2}, // R2 A-down sets, zero clears
    '{1'b0, 16'd19, 16'd7, 16'd5, 12'hC02, 8'd20, 8'd5,  8'd2}, // R2 B-down sets
    '{1'b1, 16'd8,  16'd3, 16'd6, 12'h0B0, 8'd16, 8'd10, 8'd3}, // R3 A up sets, A down clears
    '{1'b1, 16'd10, 16'd2, 16'd7, 12'h830, 8'd20, 8'd11, 8'd3}, // R3 A up sets, B down clears
    '{1'b0, 16'd3,  16'd1, 16'd2, 12'h001, 8'd8,  8'd4,  8'd1}, // R1 invert on zero
    '{1'b0, 16'd5,  16'd0, 16'd3, 12'h0C2, 8'd6,  8'd0,  8'd5}, // R5 zero beats compare A
    '{1'b0, 16'd7,  16'd2, 16'd7, 12'hC0B, 8'd8,  8'd1,  8'd5}, // R5 top beats compare B
    '{1'b1, 16'd6,  16'd2, 16'd2, 12'hEB2, 8'd12, 8'd2,  8'd6}, // R6 B beats A both halves
    '{1'b0, 16'd5,  16'd2, 16'd3, 12'h332, 8'd6,  8'd0,  8'd4}, // R4 up actions dead in down mode
    '{1'b0, 16'd0,  16'd4, 16'd4, 12'h00B, 8'd4,  8'd4,  8'd7}, // R7 zero beats top, down mode
    '{1'b1, 16'd0,  16'd4, 16'd4, 12'h00B, 8'd4,  8'd4,  8'd7}  // R7 zero beats top, up/down mode
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic measure_run(output int n);
    logic v;
    v = pwm_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pwm_out == v && n < 200);
  endtask

  task automatic run_vec(input vec_t v);
    int highs;
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    updown_mode = v.mode;
    load_val = v.ld;
    cmpa_val = v.ca;
    cmpb_val = v.cb;
    act_word = v.act;
    enable = 1'b1;
    repeat (3 * int'(v.win)) @(negedge clk);
    highs = 0;
    for (int k = 0; k < int'(v.win); k++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check($sformatf("R%0d vector", v.req), highs, int'(v.highs));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic held;
    repeat (3) @(negedge clk);
    check("R8 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;

    // R9: disabled with a zero action of drive-high: nothing happens
    act_word = 12'h003;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
    check("R9 no events while disabled", n, 0);

    // R11: first zero event shows one edge later, not before
    enable = 1'b1;
    #1;
    check("R11 unchanged before edge", int'(pwm_out), 0);
    @(negedge clk);
    check("R11 set after first edge", int'(pwm_out), 1);

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R9: hold on disable, restart from zero on enable (invert on zero)
    run_vec(VT[4]);
    @(negedge clk);
    enable = 1'b0;
    held = pwm_out;
    repeat (15) @(negedge clk);
    check("R9 output held while disabled", int'(pwm_out), int'(held));
    enable = 1'b1;
    @(negedge clk);
    check("R9 zero event on restart", int'(pwm_out), int'(!held));

    // R10: load change mid-period waits for the next zero
    enable = 1'b0;
    updown_mode = 1'b0;
    load_val = 16'd9;
    act_word = 12'h001;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    measure_run(n);
    load_val = 16'd3;
    measure_run(n);
    check("R10 current period kept", n, 10);
    measure_run(n);
    check("R10 new period after zero", n, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule